// File: doc/BRIEF.md
# Serial Command-Byte Register Interface

This block is the serial slave front end of a converter-style peripheral. A host drives a serial clock, a data input and an active-low select; the block answers on a data output. Each access opens with an 8-bit command byte. The byte picks the direction and one of eight internal registers, and it can also arm a continuous-readout mode for the conversion result. Once the selected register has been shifted in or out, the block waits for the next command byte.

All serial signals are sampled in the system clock domain. Edges of the serial clock are found by comparing each sample with the one before. The converter core supplies a ready level and a 24-bit result. The mode, configuration and GPIO-control registers are also driven out as ports for the rest of the chip. A host that has lost track of the framing can send a long run of ones to return every register to its default and restart command framing.

Top module: `serial_cmd_slave`

## Requirements
- R1: A command byte starts only when a 0 is sampled on a rising serial-clock edge. While waiting, each 1 sampled is dropped. The 7 bits after that 0 complete the byte.
- R2: Command bits are taken MSB first. Bit 6 = 1 selects a read and 0 a write. Bits 5:3 give the register address. After the access the block waits for a new command byte.
- R3: Read widths by address: 0 status, 4 ID and 5 GPIO control are 8 bits; 1 mode, 2 config, 3 data, 6 offset and 7 full-scale are 24 bits. Status bit 7 is the inverse of `rdy` and its other bits read 0.
- R4: Writes to addresses 1, 2, 5, 6 and 7 update the register. A write to 3 (24 bits) or 4 (8 bits) is shifted in and discarded. After `rst_n` the registers hold: mode 0x080060, config 0x000117, GPIO 0x00, offset 0x800000, full-scale 0x553A40. ID reads 0x4D.
- R5: Read data leaves MSB first. The first bit is on `dout` before the first rising edge after the command. Each later bit follows a falling edge and stays put while the serial clock is high. `dout` is 1 whenever no read is in progress.
- R6: The data register captures `conv_data` on each rising edge of `rdy`.
- R7: When mode bit 20 is 1, a data read is 32 bits long: the 24 data bits and then the 8 status bits.
- R8: Command 0x5C sets `cont_rd`. After that, each rising edge of `rdy` loads `conv_data`, which is shifted out on the next serial-clock cycles without a command byte.
- R9: If the first 8 bits sampled on the data input during a continuous readout equal 0x58, `cont_rd` clears and the block waits for a command byte.
- R10: 40 consecutive rising edges with the data input at 1 (and select low) restore all R4 defaults, clear `cont_rd` and restart command framing. 39 ones followed by a 0 have no such effect.
- R11: Raising `cs_n` abandons any partial transfer and clears the bit counters. Register contents are kept. Registers never change while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| sclk | input | 1 | Serial clock from the host, idles high |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| rdy | input | 1 | Conversion-ready level from the converter core |
| conv_data | input | 24 | Conversion result from the converter core |
| mode_q | output | 24 | Mode register contents |
| cfg_q | output | 24 | Configuration register contents |
| gpio_q | output | 8 | GPIO-control register contents |
| cont_rd | output | 1 | Continuous readout armed |

## Verification
A serial-clock edge is recognised one system clock after it is sampled, because the edge detector holds the previous sample. Register updates, mode changes and the loading of read data therefore show up at the ports one clock after that edge, and `dout` moves one clock after a falling edge. The bench holds each serial-clock phase for four system clocks and reads `dout` in the last clock of the low phase, when the shift has long settled. Port checks on registers and `cont_rd` are taken at least three clocks after the final rising edge of the transfer that caused them. Serial reads are compared against a queue of expected words, in issue order.

// File: rtl/serial_cmd_slave.sv
module serial_cmd_slave #(
  parameter logic [7:0]  ID_VALUE    = 8'h4D,
  parameter logic [23:0] MODE_INIT   = 24'h080060,
  parameter logic [23:0] CFG_INIT    = 24'h000117,
  parameter logic [7:0]  GPIO_INIT   = 8'h00,
  parameter logic [23:0] OFFS_INIT   = 24'h800000,
  parameter logic [23:0] FSCL_INIT   = 24'h553A40,
  parameter int          RESYNC_ONES = 40,
  parameter int          APPEND_BIT  = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        din,
  output logic        dout,
  input  logic        rdy,
  input  logic [23:0] conv_data,
  output logic [23:0] mode_q,
  output logic [23:0] cfg_q,
  output logic [7:0]  gpio_q,
  output logic        cont_rd
);

  localparam int OW = $clog2(RESYNC_ONES + 1);
  localparam logic [7:0] CONT_EXIT = 8'h58;

  typedef enum logic [2:0] {S_CMD, S_WR, S_RD, S_CWAIT, S_CXFER} state_t;

  state_t      state;
  logic        sclk_q, rdy_q;
  logic [7:0]  cmd_sr;
  logic [5:0]  cnt, len;
  logic [2:0]  waddr;
  logic [22:0] in_sr;
  logic [31:0] out_sr;
  logic [23:0] data_q, offs_q, fscl_q;
  logic [OW-1:0] ones;

  logic [7:0]  cmd_next, status;
  logic [23:0] wdata;
  logic [31:0] rd_word;
  logic [5:0]  rd_len, wr_len;
  logic        rise, fall, rdy_rise, append, resync;

  assign rise     = !cs_n && sclk && !sclk_q;
  assign fall     = !cs_n && !sclk && sclk_q;
  assign rdy_rise = rdy && !rdy_q;
  assign cmd_next = {cmd_sr[6:0], din};
  assign wdata    = {in_sr, din};
  assign status   = {!rdy, 7'b0};
  assign append   = mode_q[APPEND_BIT];
  assign resync   = rise && din && (ones == OW'(RESYNC_ONES - 1));
  assign dout     = (state == S_RD || state == S_CXFER) ? out_sr[31] : 1'b1;

  always_comb begin
    rd_len = 6'd24;
    wr_len = 6'd24;
    case (cmd_next[5:3])
      3'd0:    rd_word = {status, 24'h0};
      3'd1:    rd_word = {mode_q, 8'h00};
      3'd2:    rd_word = {cfg_q, 8'h00};
      3'd3:    rd_word = {data_q, append ? status : 8'h00};
      3'd4:    rd_word = {ID_VALUE, 24'h0};
      3'd5:    rd_word = {gpio_q, 24'h0};
      3'd6:    rd_word = {offs_q, 8'h00};
      default: rd_word = {fscl_q, 8'h00};
    endcase
    if (cmd_next[5:3] inside {3'd0, 3'd4, 3'd5}) begin
      rd_len = 6'd8;
      wr_len = 6'd8;
    end
    if (cmd_next[5:3] == 3'd3 && append) rd_len = 6'd32;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_CMD;
      sclk_q  <= 1'b1;
      rdy_q   <= 1'b0;
      cmd_sr  <= '0;
      cnt     <= '0;
      len     <= '0;
      waddr   <= '0;
      in_sr   <= '0;
      out_sr  <= '1;
      data_q  <= '0;
      mode_q  <= MODE_INIT;
      cfg_q   <= CFG_INIT;
      gpio_q  <= GPIO_INIT;
      offs_q  <= OFFS_INIT;
      fscl_q  <= FSCL_INIT;
      ones    <= '0;
      cont_rd <= 1'b0;
    end else begin
      sclk_q <= sclk;
      rdy_q  <= rdy;
      if (rdy_rise) data_q <= conv_data;

      if (cs_n) begin
        cnt   <= '0;
        ones  <= '0;
        state <= cont_rd ? S_CWAIT : S_CMD;
      end else if (resync) begin
        state   <= S_CMD;
        cnt     <= '0;
        ones    <= '0;
        cont_rd <= 1'b0;
        data_q  <= '0;
        mode_q  <= MODE_INIT;
        cfg_q   <= CFG_INIT;
        gpio_q  <= GPIO_INIT;
        offs_q  <= OFFS_INIT;
        fscl_q  <= FSCL_INIT;
      end else begin
        if (rise) ones <= din ? ones + OW'(1) : '0;

        case (state)
          S_CMD: if (rise) begin
            if (cnt == 6'd0) begin
              if (!din) begin
                cnt    <= 6'd1;
                cmd_sr <= '0;
              end
            end else if (cnt != 6'd7) begin
              cmd_sr <= cmd_next;
              cnt    <= cnt + 6'd1;
            end else begin
              cmd_sr <= cmd_next;
              cnt    <= '0;
              if (cmd_next[6]) begin
                out_sr <= rd_word;
                len    <= rd_len;
                if (cmd_next[5:3] == 3'd3 && cmd_next[2]) begin
                  cont_rd <= 1'b1;
                  state   <= S_CWAIT;
                end else begin
                  state <= S_RD;
                end
              end else if (cmd_next[5:3] != 3'd0) begin
                waddr <= cmd_next[5:3];
                len   <= wr_len;
                state <= S_WR;
              end
            end
          end

          S_WR: if (rise) begin
            in_sr <= wdata[22:0];
            cnt   <= cnt + 6'd1;
            if (cnt == len - 6'd1) begin
              cnt   <= '0;
              state <= S_CMD;
              case (waddr)
                3'd1:    mode_q <= wdata;
                3'd2:    cfg_q  <= wdata;
                3'd5:    gpio_q <= wdata[7:0];
                3'd6:    offs_q <= wdata;
                3'd7:    fscl_q <= wdata;
                default: ;
              endcase
            end
          end

          S_RD: begin
            if (rise) begin
              cnt <= cnt + 6'd1;
              if (cnt == len - 6'd1) begin
                cnt   <= '0;
                state <= S_CMD;
              end
            end else if (fall && cnt != 6'd0) begin
              out_sr <= {out_sr[30:0], 1'b1};
            end
          end

          S_CWAIT: if (rdy_rise) begin
            out_sr <= {conv_data, append ? status : 8'h00};
            len    <= append ? 6'd32 : 6'd24;
            cnt    <= '0;
            state  <= S_CXFER;
          end

          S_CXFER: begin
            if (rise) begin
              cmd_sr <= cmd_next;
              cnt    <= cnt + 6'd1;
              if (cnt == 6'd7 && cmd_next == CONT_EXIT) begin
                cont_rd <= 1'b0;
                cnt     <= '0;
                state   <= S_CMD;
              end else if (cnt == len - 6'd1) begin
                cnt   <= '0;
                state <= S_CWAIT;
              end
            end else if (fall && cnt != 6'd0) begin
              out_sr <= {out_sr[30:0], 1'b1};
            end
          end

          default: state <= S_CMD;
        endcase
      end
    end
  end

endmodule

module serial_cmd_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        sclk,
  input logic        dout,
  input logic        rdy,
  input logic        cont_rd,
  input logic [23:0] mode_q,
  input logic [23:0] cfg_q,
  input logic [7:0]  gpio_q
);

  AST_IDLE_DOUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) |-> dout); // R11

  AST_REGS_HELD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(mode_q) && $stable(cfg_q) && $stable(gpio_q)); // R11

  AST_DOUT_HOLD_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && !$past(cs_n, 2) && sclk && $past(sclk) && $past(sclk, 2)
     && rdy == $past(rdy) && $past(rdy) == $past(rdy, 2)) |-> $stable(dout)); // R5

  AST_CONT_ARM_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cont_rd) |-> $past(!cs_n && sclk)); // R8

  AST_CONT_DROP_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cont_rd) |-> $past(!cs_n)); // R9

endmodule

bind serial_cmd_slave serial_cmd_slave_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dout(dout), .rdy(rdy),
  .cont_rd(cont_rd), .mode_q(mode_q), .cfg_q(cfg_q), .gpio_q(gpio_q)
);

// File: tb/test_serial_cmd_slave.sv
module test_serial_cmd_slave;

  localparam int CLK_PER = 10;

  logic        clk, rst_n, sclk, cs_n, din, rdy;
  logic        dout, cont_rd;
  logic [23:0] conv_data, mode_q, cfg_q;
  logic [7:0]  gpio_q;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] exp_val[$];
  string       exp_tag[$];
  logic [31:0] got_val[$];

  serial_cmd_slave i_serial_cmd_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .dout(dout),
    .rdy(rdy), .conv_data(conv_data), .mode_q(mode_q), .cfg_q(cfg_q),
    .gpio_q(gpio_q), .cont_rd(cont_rd)
  );

  initial clk = 1'b0;
  always #(CLK_PER / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (got_val.size() > 0 && exp_val.size() > 0)
      check(exp_tag.pop_front(), got_val.pop_front(), exp_val.pop_front());
  end

  task automatic sbit(input logic b, output logic o);
    @(negedge clk) sclk = 1'b0;
    repeat (3) @(negedge clk);
    din = b;
    o   = dout;
    @(negedge clk) sclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic shift(input int n, input logic [39:0] pat, output logic [31:0] w);
    logic o;
    w = '0;
    for (int i = 0; i < n; i++) begin
      sbit(pat[n-1-i], o);
      w = {w[30:0], o};
    end
    din = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [31:0] w;
    shift(8, {32'h0, b}, w);
  endtask

  task automatic wr(input logic [2:0] a, input int n, input logic [23:0] v);
    logic [31:0] w;
    send_byte({2'b00, a, 3'b000});
    shift(n, {16'h0, v}, w);
  endtask

  task automatic rd(input logic [2:0] a, input int n, input string tag, input logic [31:0] e);
    logic [31:0] w;
    exp_val.push_back(e);
    exp_tag.push_back(tag);
    send_byte({2'b01, a, 3'b000});
    shift(n, 40'h0, w);
    got_val.push_back(w);
  endtask

  task automatic cont_frame(input logic [23:0] d, input int n, input logic [39:0] pat,
                            input string tag, input logic [31:0] e);
    logic [31:0] w;
    conv_data = d;
    exp_val.push_back(e);
    exp_tag.push_back(tag);
    @(negedge clk) rdy = 1'b1;
    repeat (3) @(negedge clk);
    shift(n, pat, w);
    got_val.push_back(w);
    rdy = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    rst_n = 1'b0; sclk = 1'b1; cs_n = 1'b1; din = 1'b0; rdy = 1'b0; conv_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    check("R5 idle dout", {31'h0, dout}, 32'h1);
    check("R4 mode default", {8'h0, mode_q}, 32'h080060);
    check("R4 config default", {8'h0, cfg_q}, 32'h000117);
    check("R8 cont_rd after reset", {31'h0, cont_rd}, 32'h0);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);

    // R1: leading ones are dropped before the gate zero
    shift(3, 40'h7, w);
    wr(3'd1, 24, 24'h0A5A5A);
    rd(3'd1, 24, "R1 mode after gated write", 32'h0A5A5A);
    check("R4 mode port", {8'h0, mode_q}, 32'h0A5A5A);

    // R2/R4: writes and reads across the map
    wr(3'd2, 24, 24'hC3A5F0);
    rd(3'd2, 24, "R2 config readback", 32'hC3A5F0);
    wr(3'd5, 8, 24'h00005A);
    rd(3'd5, 8, "R4 gpio readback", 32'h5A);
    check("R4 gpio port", {24'h0, gpio_q}, 32'h5A);
    wr(3'd6, 24, 24'h0F1E2D);
    rd(3'd6, 24, "R4 offset readback", 32'h0F1E2D);
    wr(3'd7, 24, 24'h00FF00);
    rd(3'd7, 24, "R4 full-scale readback", 32'h00FF00);
    check("R5 dout high after read", {31'h0, dout}, 32'h1);

    // R3/R6: status and data capture
    rd(3'd0, 8, "R3 status while not ready", 32'h80);
    conv_data = 24'hABCDEF;
    @(negedge clk) rdy = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd0, 8, "R3 status while ready", 32'h00);
    rdy = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd3, 24, "R6 data captured", 32'hABCDEF);

    // R4: discarded writes to data and ID
    wr(3'd3, 24, 24'h111111);
    rd(3'd3, 24, "R4 data write discarded", 32'hABCDEF);
    wr(3'd4, 8, 24'h0000FF);
    rd(3'd4, 8, "R4 ID read", 32'h4D);

    // R7: data plus status
    wr(3'd1, 24, 24'h1A5A5A);
    rd(3'd3, 32, "R7 data with status", 32'hABCDEF80);
    wr(3'd1, 24, 24'h0A5A5A);
    rd(3'd3, 24, "R7 data without status", 32'hABCDEF);

    // R11: abandoned write
    send_byte(8'h10);
    shift(10, 40'h2AA, w);
    @(negedge clk) cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 dout high while deselected", {31'h0, dout}, 32'h1);
    check("R11 config kept", {8'h0, cfg_q}, 32'hC3A5F0);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    rd(3'd2, 24, "R11 config after abort", 32'hC3A5F0);

    // R8: continuous readout
    send_byte(8'h5C);
    check("R8 cont_rd set", {31'h0, cont_rd}, 32'h1);
    cont_frame(24'h13579B, 24, 40'h0, "R8 first frame", 32'h13579B);
    cont_frame(24'h2468AC, 24, 40'h0, "R8 second frame", 32'h2468AC);

    // R9: exit code during a readout
    cont_frame(24'h777777, 8, 40'h58, "R9 truncated frame", 32'h77);
    check("R9 cont_rd cleared", {31'h0, cont_rd}, 32'h0);
    rd(3'd5, 8, "R9 command after exit", 32'h5A);

    // R10: resync run
    shift(39, 40'h7FFFFFFFFF, w);
    rd(3'd5, 8, "R10 39 ones no reset", 32'h5A);
    check("R10 mode kept after 39 ones", {8'h0, mode_q}, 32'h0A5A5A);
    shift(40, 40'hFFFFFFFFFF, w);
    repeat (2) @(negedge clk);
    check("R10 mode restored", {8'h0, mode_q}, 32'h080060);
    check("R10 config restored", {8'h0, cfg_q}, 32'h000117);
    check("R10 gpio restored", {24'h0, gpio_q}, 32'h00);
    rd(3'd6, 24, "R10 offset restored", 32'h800000);
    rd(3'd7, 24, "R10 full-scale restored", 32'h553A40);

    repeat (20) @(negedge clk);
    if (exp_val.size() != 0) check("R5 pending reads", exp_val.size(), 0);
    finish_run();
  end

endmodule